// File: doc/BRIEF.md
# Serial LED Cascade Driver

This peripheral feeds an external chain of serial-in, parallel-out shift registers, usually the ones that light board LEDs. Software writes a data word and configuration through a small 32-bit register bus. On request, the block sends the low bits of the data word out one at a time on a serial data line, with a divided shift clock. After the last bit it raises a one-cycle store strobe, so the external registers present all their outputs together. The cascade holds one, two or three 8-bit groups. The highest enabled group sets how long the frame is.

A frame starts in one of two ways: software sets a request bit, or an internal rate timer fires while automatic refresh is selected. Each of the lowest eight output positions can be handed to a hardware status input instead of software data. Bits 0 and 1 go to a modem status pair, bits 2 to 4 to a first PHY status triple, and bits 5 to 7 to a second PHY status triple. Automatic refresh keeps those hardware-owned outputs current without software involvement. A control bit chooses whether the external registers take data on the rising or the falling edge of the shift clock.

Top module: `ledshift_ctrl`

## Requirements
- R1: `bus_addr` is a word index. 0 selects control A, 1 control B, 2 data A, 3 data B and 4 a spare scratch word. A write to any of these is read back unchanged on `bus_rdata`, except control A bit 31. Any other index reads zero. After reset every register reads zero and `sr_data`, `sr_clk` and `sr_store` are low.
- R2: The group enables are control B bits [2:0]. The frame has 8×(h+1) bits, where h is the index of the highest set enable bit. With no group enabled, a request is discarded and nothing is shifted.
- R3: Writing 1 to control A bit 31 posts a software request. The bit reads 1 while the request waits and returns to 0 when the request is taken at frame start. Writing 0 to it never cancels a waiting request.
- R4: Control A bit 26 selects the shift edge. With 0, `sr_clk` idles low and data is valid at its rising edge. With 1, `sr_clk` idles high and data is valid at its falling edge.
- R5: Frame bits leave the block highest position first, down to position 0, one per `2*HALF_DIV` system cycles. Exactly one `sr_store` cycle follows the last bit, with `sr_clk` at its idle level.
- R6: Control B bits [31:30] equal to 2'b10 enable automatic refresh. Frames then repeat every `SYS_HZ/rate` cycles, where control B bits [24:23] give the rate: 00 = 2, 01 = 4, 10 = 8, 11 = 10 per second. Any other source value disables refresh.
- R7: Control A bits [25:24] are an ownership mask. A set bit k (k = 0 or 1) makes frame position k carry `modem_st[k]` instead of data A bit k.
- R8: Control A bits [29:27] hand frame positions 2 to 4 to `phy1_st[2:0]`. Control B bits [17:15] hand positions 5 to 7 to `phy2_st[2:0]`. Mask bit j drives position base+j.
- R9: Hardware status and data A are captured at the cycle a frame starts. Later changes to them do not affect that frame.
- R10: A request raised while a frame is being shifted is held and served by a fresh frame right after the current store strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| modem_st | input | 2 | Modem status for frame positions 0-1 |
| phy1_st | input | 3 | First PHY status for positions 2-4 |
| phy2_st | input | 3 | Second PHY status for positions 5-7 |
| sr_data | output | 1 | Serial data to the cascade |
| sr_clk | output | 1 | Shift clock to the cascade |
| sr_store | output | 1 | One-cycle latch strobe after the last bit |

## Verification
The case hardest to reach from the ports is a request that lands while a frame is still shifting. The bench starts a 24-bit frame and, in the middle of its shift, writes a new data word and sets the request bit again. It reads the pending bit back and then writes a 0 over it. It then expects two frames back to back, the first with the old word and the second with the new one. Hardware capture at frame start is reached the same way: the status inputs are flipped a few cycles after a frame has begun. Every ownership mask combination is swept against complementary data and status patterns.

// File: rtl/ledshift_pkg.sv
package ledshift_pkg;
  localparam int unsigned NGRP      = 3;
  localparam int unsigned GW        = 8;
  localparam int unsigned FRAME_MAX = NGRP * GW;
  localparam int unsigned LW        = $clog2(FRAME_MAX + 1);
  localparam int unsigned HWBITS    = 8;

  localparam logic [2:0] A_CTLA = 3'd0;
  localparam logic [2:0] A_CTLB = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_DATB = 3'd3;
  localparam logic [2:0] A_SPARE = 3'd4;

  typedef enum logic [1:0] {FS_IDLE, FS_SHIFT, FS_STORE} fstate_e;
endpackage

// File: rtl/ledshift_regs.sv
module ledshift_regs
  import ledshift_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [2:0]           addr,
  input  logic [31:0]          wdata,
  input  logic                 take,
  output logic [31:0]          rdata,
  output logic                 swu,
  output logic                 edge_fall,
  output logic [1:0]           modem_own,
  output logic [2:0]           phy1_own,
  output logic [2:0]           phy2_own,
  output logic [NGRP-1:0]      grp,
  output logic [1:0]           rate,
  output logic [1:0]           src,
  output logic [FRAME_MAX-1:0] dat
);
  logic [31:0] ca_q, cb_q, da_q, db_q, sp_q;
  logic [31:0] ca_d, cb_d, da_d, db_d, sp_d;
  logic        pend;

  always_comb begin
    pend = ca_q[31] & ~take;
    ca_d = {pend, ca_q[30:0]};
    cb_d = cb_q;
    da_d = da_q;
    db_d = db_q;
    sp_d = sp_q;
    if (we) begin
      case (addr)
        A_CTLA:  ca_d = {pend | wdata[31], wdata[30:0]};
        A_CTLB:  cb_d = wdata;
        A_DATA:  da_d = wdata;
        A_DATB:  db_d = wdata;
        A_SPARE: sp_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      cb_q <= '0;
      da_q <= '0;
      db_q <= '0;
      sp_q <= '0;
    end else begin
      ca_q <= ca_d;
      cb_q <= cb_d;
      da_q <= da_d;
      db_q <= db_d;
      sp_q <= sp_d;
    end
  end

  always_comb begin
    case (addr)
      A_CTLA:  rdata = ca_q;
      A_CTLB:  rdata = cb_q;
      A_DATA:  rdata = da_q;
      A_DATB:  rdata = db_q;
      A_SPARE: rdata = sp_q;
      default: rdata = '0;
    endcase
  end

  assign swu       = ca_q[31];
  assign edge_fall = ca_q[26];
  assign modem_own = ca_q[25:24];
  assign phy1_own  = ca_q[29:27];
  assign phy2_own  = cb_q[17:15];
  assign grp       = cb_q[NGRP-1:0];
  assign rate      = cb_q[24:23];
  assign src       = cb_q[31:30];
  assign dat       = da_q[FRAME_MAX-1:0];
endmodule

// File: rtl/ledshift_timer.sv
module ledshift_timer #(
  parameter int unsigned SYS_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam logic [31:0] PER2  = 32'(SYS_HZ / 2);
  localparam logic [31:0] PER4  = 32'(SYS_HZ / 4);
  localparam logic [31:0] PER8  = 32'(SYS_HZ / 8);
  localparam logic [31:0] PER10 = 32'(SYS_HZ / 10);

  logic [31:0] per, cnt_q, cnt_d;

  always_comb begin
    case (rate)
      2'b00:   per = PER2;
      2'b01:   per = PER4;
      2'b10:   per = PER8;
      default: per = PER10;
    endcase
  end

  assign tick = en && (cnt_q >= per - 32'd1);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ledshift_frame.sv
module ledshift_frame
  import ledshift_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [NGRP-1:0]      grp,
  input  logic [FRAME_MAX-1:0] dat,
  input  logic [HWBITS-1:0]    own,
  input  logic [HWBITS-1:0]    hw,
  output logic                 take,
  output logic                 sdata,
  output logic                 sclk_hi,
  output logic                 store
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  fstate_e              st_q, st_d;
  logic [FRAME_MAX-1:0] sh_q, sh_d, merged;
  logic [LW-1:0]        idx_q, idx_d, len;
  logic                 half_q, half_d;
  logic [DW-1:0]        div_q, div_d;
  logic                 start;

  for (genvar b = 0; b < HWBITS; b++) begin : g_own
    assign merged[b] = own[b] ? hw[b] : dat[b];
  end
  assign merged[FRAME_MAX-1:HWBITS] = dat[FRAME_MAX-1:HWBITS];

  always_comb begin
    len = '0;
    for (int g = 0; g < NGRP; g++)
      if (grp[g]) len = LW'((g + 1) * GW);
  end

  assign take  = (st_q == FS_IDLE) && req;
  assign start = take && (len != '0);

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    half_d = half_q;
    div_d  = div_q;
    case (st_q)
      FS_IDLE: if (start) begin
        sh_d   = merged;
        idx_d  = len - LW'(1);
        half_d = 1'b0;
        div_d  = '0;
        st_d   = FS_SHIFT;
      end
      FS_SHIFT: begin
        if (div_q == DIV_LAST) begin
          div_d = '0;
          if (!half_q) begin
            half_d = 1'b1;
          end else begin
            half_d = 1'b0;
            if (idx_q == '0) st_d = FS_STORE;
            else             idx_d = idx_q - LW'(1);
          end
        end else begin
          div_d = div_q + DW'(1);
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      sh_q   <= '0;
      idx_q  <= '0;
      half_q <= 1'b0;
      div_q  <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      half_q <= half_d;
      div_q  <= div_d;
    end
  end

  assign sdata   = (st_q == FS_SHIFT) ? sh_q[idx_q] : 1'b0;
  assign sclk_hi = (st_q == FS_SHIFT) && half_q;
  assign store   = (st_q == FS_STORE);
endmodule

// File: rtl/ledshift_ctrl.sv
module ledshift_ctrl
  import ledshift_pkg::*;
#(
  parameter int unsigned SYS_HZ   = 100_000_000,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  modem_st,
  input  logic [2:0]  phy1_st,
  input  logic [2:0]  phy2_st,
  output logic        sr_data,
  output logic        sr_clk,
  output logic        sr_store
);
  logic [1:0]           rs_q;
  logic                 rst_s_n;
  logic                 swu, edge_fall, take, tick, auto_pend_q, auto_pend_d;
  logic                 sclk_hi;
  logic [1:0]           modem_own, rate, src;
  logic [2:0]           phy1_own, phy2_own;
  logic [NGRP-1:0]      grp;
  logic [FRAME_MAX-1:0] dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  ledshift_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .take(take), .rdata(bus_rdata), .swu(swu),
    .edge_fall(edge_fall), .modem_own(modem_own), .phy1_own(phy1_own),
    .phy2_own(phy2_own), .grp(grp), .rate(rate), .src(src), .dat(dat)
  );

  ledshift_timer #(.SYS_HZ(SYS_HZ)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .en(src == 2'b10), .rate(rate), .tick(tick)
  );

  always_comb begin
    auto_pend_d = auto_pend_q;
    if (take) auto_pend_d = 1'b0;
    if (tick) auto_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) auto_pend_q <= 1'b0;
    else          auto_pend_q <= auto_pend_d;
  end

  ledshift_frame #(.HALF_DIV(HALF_DIV)) u_frame (
    .clk(clk), .rst_n(rst_s_n), .req(swu | auto_pend_q), .grp(grp),
    .dat(dat), .own({phy2_own, phy1_own, modem_own}),
    .hw({phy2_st, phy1_st, modem_st}), .take(take), .sdata(sr_data),
    .sclk_hi(sclk_hi), .store(sr_store)
  );

  assign sr_clk = sclk_hi ^ edge_fall;
endmodule

// File: rtl/ledshift_chk.sv
module ledshift_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_hi,
  input logic       sr_clk,
  input logic       sr_store,
  input logic       edge_fall,
  input logic [2:0] grp,
  input logic       take,
  input logic       swu,
  input logic       set_req
);
  logic       prev_q;
  logic [5:0] ecnt_q;
  logic [5:0] exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      ecnt_q <= '0;
    end else begin
      prev_q <= sclk_hi;
      if (sr_store)               ecnt_q <= '0;
      else if (sclk_hi && !prev_q) ecnt_q <= ecnt_q + 6'd1;
    end
  end

  assign exp_len = grp[2] ? 6'd24 : grp[1] ? 6'd16 : grp[0] ? 6'd8 : 6'd0;

  a_r5_store_single: assert property (@(posedge clk) disable iff (!rst_n)
    sr_store |=> !sr_store);
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    sr_store |-> (sr_clk == edge_fall));
  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    sr_store |-> (ecnt_q == exp_len));
  a_r3_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !set_req) |=> !swu);
  a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_hi |-> !take);
endmodule

bind ledshift_ctrl ledshift_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .sclk_hi(sclk_hi), .sr_clk(sr_clk),
  .sr_store(sr_store), .edge_fall(edge_fall), .grp(grp), .take(take),
  .swu(swu), .set_req(bus_we && (bus_addr == 3'd0) && bus_wdata[31])
);

// File: tb/sim_ledshift_ctrl.sv
module sim_ledshift_ctrl;
  localparam int SYS_HZ = 4000;
  localparam int HALF   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  modem_st = '0;
  logic [2:0]  phy1_st = '0;
  logic [2:0]  phy2_st = '0;
  logic        sr_data, sr_clk, sr_store;

  int total = 0;
  int bad = 0;
  int frames = 0;
  int cyc = 0;
  int last_len = 0;
  int nb = 0;
  int t_store = 0;
  logic [23:0] cap = '0, last_word = '0, prev_word = '0;
  logic mode_fall = 1'b0;
  logic prv = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  ledshift_ctrl #(.SYS_HZ(SYS_HZ), .HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .modem_st(modem_st),
    .phy1_st(phy1_st), .phy2_st(phy2_st), .sr_data(sr_data),
    .sr_clk(sr_clk), .sr_store(sr_store)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic raw;
    raw = sr_clk ^ mode_fall;
    if (raw && !prv) begin
      cap = {cap[22:0], sr_data};
      nb  = nb + 1;
    end
    prv = raw;
    if (sr_store) begin
      prev_word = last_word;
      last_word = cap;
      last_len  = nb;
      frames    = frames + 1;
      t_store   = cyc;
      cap = '0;
      nb  = 0;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ca(input logic f, input logic [1:0] m, input logic [2:0] p1);
    return (32'(f) << 26) | (32'(m) << 24) | (32'(p1) << 27);
  endfunction

  function automatic logic [31:0] cb(input logic [2:0] g, input logic [2:0] p2,
                                     input logic [1:0] r, input logic [1:0] s);
    return 32'(g) | (32'(p2) << 15) | (32'(r) << 23) | (32'(s) << 30);
  endfunction

  function automatic int flen(input logic [2:0] g);
    return g[2] ? 24 : g[1] ? 16 : g[0] ? 8 : 0;
  endfunction

  function automatic logic [23:0] fexp(input logic [2:0] g, input logic [23:0] d,
                                       input logic [7:0] own, input logic [7:0] hw);
    logic [23:0] w;
    w = {d[23:8], (d[7:0] & ~own) | (hw & own)};
    return w & ((24'h1 << flen(g)) - 24'h1);
  endfunction

  task automatic set_mode(input logic f, input logic [1:0] m, input logic [2:0] p1);
    wr(3'd0, ca(f, m, p1));
    #1;
    mode_fall = f; prv = 1'b0; cap = '0; nb = 0;
    @(negedge clk);
  endtask

  task automatic wait_frames(input int n, input int lim, output logic ok);
    int f0 = frames;
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (frames >= f0 + n) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_frame(input logic [31:0] cav, output logic ok);
    wr(3'd0, cav | 32'h8000_0000);
    wait_frames(1, 400, ok);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic ok;
    logic [23:0] dv, ex;
    logic [7:0] hwv;
    int t1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(sr_data == 0 && sr_clk == 0 && sr_store == 0, "R1 reset outputs",
        {sr_data, sr_clk, sr_store}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      chk(rv == 0, "R1 reset read", rv, 0);
    end
    @(negedge clk);

    // R1: readback
    wr(3'd3, 32'hDEAD_BEEF);
    wr(3'd4, 32'h1234_5678);
    wr(3'd2, 32'hCAFE_0F0F);
    wr(3'd1, cb(3'd0, 3'd5, 2'd2, 2'd1));
    wr(3'd0, 32'h4ABC_DEF0);
    rd(3'd3, rv); chk(rv == 32'hDEAD_BEEF, "R1 data B", rv, 32'hDEAD_BEEF);
    rd(3'd4, rv); chk(rv == 32'h1234_5678, "R1 spare", rv, 32'h1234_5678);
    rd(3'd2, rv); chk(rv == 32'hCAFE_0F0F, "R1 data A", rv, 32'hCAFE_0F0F);
    rd(3'd1, rv); chk(rv == cb(3'd0, 3'd5, 2'd2, 2'd1), "R1 ctl B", rv, cb(3'd0, 3'd5, 2'd2, 2'd1));
    rd(3'd0, rv); chk(rv == 32'h4ABC_DEF0, "R1 ctl A", rv, 32'h4ABC_DEF0);
    rd(3'd6, rv); chk(rv == 0, "R1 unmapped", rv, 0);
    @(negedge clk);
    set_mode(1'b0, 2'd0, 3'd0);

    // R2 R5: every group combination, two data patterns, rising edge
    for (int g = 1; g < 8; g++) begin
      for (int p = 0; p < 2; p++) begin
        dv = (p == 0) ? 24'hA55A_3C : 24'h1E_C381 ^ 24'(g * 24'h010203);
        wr(3'd1, cb(3'(g), 3'd0, 2'd0, 2'd0));
        wr(3'd2, {8'h00, dv});
        do_frame(ca(1'b0, 2'd0, 3'd0), ok);
        ex = fexp(3'(g), dv, 8'h00, 8'h00);
        chk(ok && last_len == flen(3'(g)), "R2 frame length", last_len, flen(3'(g)));
        chk(last_word == ex, "R5 bit order", last_word, ex);
      end
    end

    // R7 R8: all ownership masks
    for (int m = 0; m < 4; m++)
      for (int p1 = 0; p1 < 8; p1++)
        for (int p2 = 0; p2 < 8; p2++) begin
          dv  = ((m + p1 + p2) % 2 == 0) ? 24'h00005A : 24'h0000C6;
          hwv = ~dv[7:0];
          {phy2_st, phy1_st, modem_st} = hwv;
          wr(3'd1, cb(3'd1, 3'(p2), 2'd0, 2'd0));
          wr(3'd2, {8'h00, dv});
          do_frame(ca(1'b0, 2'(m), 3'(p1)), ok);
          ex = fexp(3'd1, dv, {3'(p2), 3'(p1), 2'(m)}, hwv);
          chk(ok && last_word == ex, (m != 0) ? "R7 modem ownership" : "R8 phy ownership",
              last_word, ex);
        end

    // R9: hardware sampled at frame start
    wr(3'd2, 32'h0);
    {phy2_st, phy1_st, modem_st} = 8'h3C;
    wr(3'd0, ca(1'b0, 2'd3, 3'd7) | 32'h8000_0000);
    repeat (8) @(negedge clk);
    {phy2_st, phy1_st, modem_st} = 8'hC3;
    wait_frames(1, 400, ok);
    chk(ok && last_word == 24'h3C, "R9 capture at start", last_word, 24'h3C);
    wr(3'd0, ca(1'b0, 2'd0, 3'd0));

    // R10 R3: request during an active 24-bit frame
    wr(3'd1, cb(3'd7, 3'd0, 2'd0, 2'd0));
    wr(3'd2, 32'h00F0_0F55);
    wr(3'd0, ca(1'b0, 2'd0, 3'd0) | 32'h8000_0000);
    repeat (10) @(negedge clk);
    wr(3'd2, 32'h0033_CC99);
    wr(3'd0, ca(1'b0, 2'd0, 3'd0) | 32'h8000_0000);
    rd(3'd0, rv);
    chk(rv[31] == 1'b1, "R3 pending reads one", rv[31], 1);
    @(negedge clk);
    wr(3'd0, ca(1'b0, 2'd0, 3'd0));
    rd(3'd0, rv);
    chk(rv[31] == 1'b1, "R3 zero write keeps request", rv[31], 1);
    @(negedge clk);
    wait_frames(2, 400, ok);
    chk(ok && prev_word == 24'hF00F55, "R10 first frame", prev_word, 24'hF00F55);
    chk(last_word == 24'h33CC99, "R10 held frame", last_word, 24'h33CC99);
    rd(3'd0, rv);
    chk(rv[31] == 1'b0, "R3 cleared after start", rv[31], 0);
    @(negedge clk);

    // R4: falling edge mode
    set_mode(1'b1, 2'd0, 3'd0);
    chk(sr_clk == 1'b1, "R4 idle high", sr_clk, 1);
    for (int g = 1; g < 8; g += 3) begin
      wr(3'd1, cb(3'(g), 3'd0, 2'd0, 2'd0));
      wr(3'd2, 32'h0069_E21B);
      do_frame(ca(1'b1, 2'd0, 3'd0), ok);
      ex = fexp(3'(g), 24'h69E21B, 8'h00, 8'h00);
      chk(ok && last_word == ex && last_len == flen(3'(g)), "R4 falling frame", last_word, ex);
    end
    set_mode(1'b0, 2'd0, 3'd0);
    chk(sr_clk == 1'b0, "R4 idle low", sr_clk, 0);

    // R2 R3: no group enabled
    wr(3'd1, cb(3'd0, 3'd0, 2'd0, 2'd0));
    t1 = frames;
    wr(3'd0, 32'h8000_0000);
    repeat (150) @(negedge clk);
    chk(frames == t1, "R2 no groups no frame", frames - t1, 0);
    rd(3'd0, rv);
    chk(rv[31] == 1'b0, "R3 discarded request clears", rv[31], 0);
    @(negedge clk);

    // R6: automatic refresh periods
    for (int r = 0; r < 4; r++) begin
      int per;
      per = SYS_HZ / ((r == 0) ? 2 : (r == 1) ? 4 : (r == 2) ? 8 : 10);
      wr(3'd1, cb(3'd1, 3'd0, 2'(r), 2'd2));
      wait_frames(2, 2 * per + 200, ok);
      t1 = t_store;
      wait_frames(1, per + 200, ok);
      chk(ok && (t_store - t1) == per, "R6 refresh period", t_store - t1, per);
    end
    wr(3'd1, cb(3'd1, 3'd0, 2'd3, 2'd1));
    repeat (200) @(negedge clk);
    t1 = frames;
    repeat (2500) @(negedge clk);
    chk(frames == t1, "R6 other source disables", frames - t1, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule